// File: doc/BRIEF.md
# Packed Widening Absolute-Difference Accumulator

This block is a SIMD arithmetic stage. Each cycle it can accept two 64-bit packed source vectors and a 128-bit packed accumulator. For every lane it takes the absolute difference of the two narrow source elements, widens it to twice the element width, and adds it to the matching accumulator lane. One clock later it presents the updated 128-bit accumulator together with a one-cycle result strobe.

A two-bit size code chooses 8-, 16- or 32-bit elements. A flag chooses whether elements are read as unsigned or as two's-complement signed. The stage also checks that the operation is legal. A size code that names no element width is illegal, and so is a destination register index whose low bit is set. An illegal request raises an illegal flag in place of the result strobe and leaves the result register untouched. Latency is always one cycle, whatever the operand values.

Top module: `absacc_widen`

## Requirements
- R1: The element width is 8 shifted left by `sizeSel` (0→8, 1→16, 2→32 bits). There are 64/width active lanes, and lane 0 occupies the least significant bits of `srcA`, `srcB`, `accIn` and `accOut`. Result lane e spans bits [e·2W +: 2W].
- R2: When `isUnsigned` is 1, elements are read as unsigned. When it is 0, they are read as two's-complement signed.
- R3: The absolute difference is exact for every input pair. Signed −128 against 127 gives 255, and unsigned 0 against 255 gives 255.
- R4: Each result lane equals its accumulator lane plus the absolute difference, modulo 2^(2W). No carry passes into the next lane.
- R5: A valid request with `sizeSel` = 3 sets `illegalOp` high for exactly the next cycle, keeps `accValid` low, and leaves `accOut` unchanged.
- R6: A valid request with `dstIdxLsb` = 1 behaves as in R5, whatever the size code.
- R7: A legal valid request updates `accOut` and pulses `accValid` for one cycle, exactly one clock after the request. This holds for every operand value.
- R8: With `reqValid` low, neither strobe rises and `accOut` holds its value.
- R9: After reset, `accOut` is zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| sizeSel | input | 2 | Element size code |
| isUnsigned | input | 1 | 1 = unsigned elements, 0 = signed |
| dstIdxLsb | input | 1 | Low bit of destination register index |
| srcA | input | 64 | Packed minuend elements |
| srcB | input | 64 | Packed subtrahend elements |
| accIn | input | 128 | Packed double-width accumulator lanes |
| accOut | output | 128 | Registered updated accumulator |
| accValid | output | 1 | One-cycle strobe for a new result |
| illegalOp | output | 1 | One-cycle strobe for a rejected request |

## Verification
Two things can land in adjacent cycles: the capture of a legal result and the rejection of an illegal request. A legal request is followed at once by an illegal one. The bench then checks that the first request's result appears with `accValid`, and that on the next cycle `illegalOp` rises while `accOut` keeps that first result. Both illegal causes are also applied together in a single request, and the bench expects exactly one `illegalOp` pulse with no result update.

// File: rtl/absacc_pkg.sv
package absacc_pkg;
  localparam int SRC_W     = 64;
  localparam int ACC_W     = 2 * SRC_W;
  localparam int ELEM_BASE = 8;
  localparam int NUM_SIZES = 3;
  localparam int SIZE_W    = 2;

  typedef struct packed {
    logic load;   // legal request: capture the new accumulator
    logic reject; // illegal request: flag it, keep the result
  } ctrlStrobes_t;
endpackage

// File: rtl/absacc_lane.sv
module absacc_lane #(
  parameter int W = 8
) (
  input  logic             isUnsigned,
  input  logic [W-1:0]     elemA,
  input  logic [W-1:0]     elemB,
  input  logic [2*W-1:0]   accLane,
  output logic [2*W-1:0]   sumLane
);
  logic signed [W:0] extA;
  logic signed [W:0] extB;
  logic signed [W:0] diff;
  logic        [W:0] magnitude;

  // one extra bit keeps the difference exact in both interpretations
  assign extA = {isUnsigned ? 1'b0 : elemA[W-1], elemA};
  assign extB = {isUnsigned ? 1'b0 : elemB[W-1], elemB};
  assign diff = extA - extB;
  assign magnitude = diff[W] ? W'(0) - diff : diff;
  assign sumLane = accLane + {{(W-1){1'b0}}, magnitude};
endmodule

// File: rtl/absacc_ctrl.sv
module absacc_ctrl
  import absacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              dstIdxLsb,
  output ctrlStrobes_t      strobes,
  output logic              accValid,
  output logic              illegalOp
);
  logic sizeOk;
  logic bad;

  assign sizeOk  = (sizeSel < SIZE_W'(NUM_SIZES));
  assign bad     = !sizeOk || dstIdxLsb;
  assign strobes.load   = reqValid && !bad;
  assign strobes.reject = reqValid && bad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      accValid  <= strobes.load;
      illegalOp <= strobes.reject;
    end
  end
endmodule

// File: rtl/absacc_datapath.sv
module absacc_datapath
  import absacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              isUnsigned,
  input  logic [SRC_W-1:0]  srcA,
  input  logic [SRC_W-1:0]  srcB,
  input  logic [ACC_W-1:0]  accIn,
  output logic [ACC_W-1:0]  accOut
);
  logic [ACC_W-1:0] variantSum [NUM_SIZES];
  logic [ACC_W-1:0] nextSum;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    localparam int W     = ELEM_BASE << g;
    localparam int LANES = SRC_W / W;
    for (genvar e = 0; e < LANES; e++) begin : gLane
      absacc_lane #(.W(W)) uLane (
        .isUnsigned (isUnsigned),
        .elemA      (srcA[e*W +: W]),
        .elemB      (srcB[e*W +: W]),
        .accLane    (accIn[e*2*W +: 2*W]),
        .sumLane    (variantSum[g][e*2*W +: 2*W])
      );
    end
  end

  always_comb begin
    nextSum = accIn;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (sizeSel == SIZE_W'(g)) nextSum = variantSum[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             accOut <= '0;
    else if (strobes.load) accOut <= nextSum;
  end

  logic unusedReject;
  assign unusedReject = strobes.reject;
endmodule

// File: rtl/absacc_widen.sv
module absacc_widen
  import absacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              isUnsigned,
  input  logic              dstIdxLsb,
  input  logic [SRC_W-1:0]  srcA,
  input  logic [SRC_W-1:0]  srcB,
  input  logic [ACC_W-1:0]  accIn,
  output logic [ACC_W-1:0]  accOut,
  output logic              accValid,
  output logic              illegalOp
);
  ctrlStrobes_t strobes;

  absacc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .sizeSel   (sizeSel),
    .dstIdxLsb (dstIdxLsb),
    .strobes   (strobes),
    .accValid  (accValid),
    .illegalOp (illegalOp)
  );

  absacc_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sizeSel    (sizeSel),
    .isUnsigned (isUnsigned),
    .srcA       (srcA),
    .srcB       (srcB),
    .accIn      (accIn),
    .accOut     (accOut)
  );
endmodule

// File: rtl/absacc_widen_chk.sv
module absacc_widen_chk (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [1:0]   sizeSel,
  input logic         dstIdxLsb,
  input logic [127:0] accOut,
  input logic         accValid,
  input logic         illegalOp
);
  assert_bad_size_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeSel == 2'd3) |=> (illegalOp && !accValid));

  assert_bad_dst_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && dstIdxLsb) |=> (illegalOp && !accValid));

  assert_hold_on_illegal_R5: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> $stable(accOut));

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeSel != 2'd3 && !dstIdxLsb) |=> (accValid && !illegalOp));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!accValid && !illegalOp && $stable(accOut)));

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accValid, illegalOp}));
endmodule

bind absacc_widen absacc_widen_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .sizeSel   (sizeSel),
  .dstIdxLsb (dstIdxLsb),
  .accOut    (accOut),
  .accValid  (accValid),
  .illegalOp (illegalOp)
);

// File: tb/absacc_widen_test.sv
module absacc_widen_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [1:0]   sizeSel = '0;
  logic         isUnsigned = 1'b0;
  logic         dstIdxLsb = 1'b0;
  logic [63:0]  srcA = '0;
  logic [63:0]  srcB = '0;
  logic [127:0] accIn = '0;
  logic [127:0] accOut;
  logic         accValid;
  logic         illegalOp;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  absacc_widen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sizeSel(sizeSel),
    .isUnsigned(isUnsigned), .dstIdxLsb(dstIdxLsb), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .accOut(accOut), .accValid(accValid), .illegalOp(illegalOp)
  );

  typedef struct packed {
    logic [1:0]   sz;
    logic         uns;
    logic [63:0]  a;
    logic [63:0]  b;
    logic [127:0] acc;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 128'h0001_0002_0003_0004_0005_0006_0007_0008},
    '{2'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 128'hFFFF_0000_1234_8000_7FFF_FFF0_0000_0101},
    '{2'd1, 1'b1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0000, 128'h0000_0001_FFFF_FFFF_1234_5678_0000_0000},
    '{2'd1, 1'b0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0000, 128'hFFFF_FFFF_0000_0000_8000_0000_0000_0010},
    '{2'd2, 1'b1, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 128'h1111_2222_3333_4444_FFFF_FFFF_FFFF_FFF0},
    '{2'd2, 1'b0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 128'h0000_0000_0000_0000_0000_0000_0000_0000},
    '{2'd0, 1'b0, 64'h8080_7F7F_0000_FF01, 64'h7F7F_8080_0000_01FF, 128'h0000_0000_0000_0000_0000_0000_0000_0000},
    '{2'd2, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001}
  };

  // Reference model built from R1-style lane rules, R2, R3 and R4.
  function automatic logic [127:0] refCalc(input logic [1:0] sz, input logic uns,
      input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc);
    int w = 8 << sz;
    int n = 64 / w;
    logic [127:0] res = '0;
    logic [63:0] mask = (w == 32) ? {64{1'b1}} : ((64'd1 << (2 * w)) - 64'd1);
    logic [63:0] emask = (64'd1 << w) - 64'd1;
    for (int e = 0; e < n; e++) begin
      logic [63:0] ta = (a >> (e * w)) & emask;
      logic [63:0] tb = (b >> (e * w)) & emask;
      logic [127:0] tacc = acc >> (e * 2 * w);
      longint ea = longint'(ta);
      longint eb = longint'(tb);
      longint d;
      logic [63:0] sum;
      if (!uns && ta[w-1]) ea = ea - (longint'(1) << w);
      if (!uns && tb[w-1]) eb = eb - (longint'(1) << w);
      d = ea - eb;
      if (d < 0) d = -d;
      sum = (tacc[63:0] + 64'(d)) & mask;
      res = res | ({64'd0, sum} << (e * 2 * w));
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] sz, input logic uns,
      input logic dst, input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc);
    reqValid = v; sizeSel = sz; isUnsigned = uns; dstIdxLsb = dst;
    srcA = a; srcB = b; accIn = acc;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic [127:0] exp;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(accOut == '0, "R9 accOut", accOut, '0);
    check(!accValid && !illegalOp, "R9 strobes", {accValid, illegalOp}, 0);
    rstN = 1'b1;

    // Table walk: R1, R2, R4, R7
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(1'b1, VECS[i].sz, VECS[i].uns, 1'b0, VECS[i].a, VECS[i].b, VECS[i].acc);
      exp = refCalc(VECS[i].sz, VECS[i].uns, VECS[i].a, VECS[i].b, VECS[i].acc);
      @(negedge clk);
      drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
      check(accOut == exp, $sformatf("R1 R2 R4 vector %0d", i), accOut, exp);
      check(accValid && !illegalOp, "R7 valid strobe", {accValid, illegalOp}, 2'b10);
    end

    // R3: signed -128 vs 127, lane 0 at LSB
    @(negedge clk);
    drive(1'b1, 2'd0, 1'b0, 1'b0, 64'h80, 64'h7F, '0);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(accOut == 128'h00FF, "R3 signed extreme", accOut, 128'h00FF);

    // R3: unsigned 0 vs 255 in lane 1
    @(negedge clk);
    drive(1'b1, 2'd0, 1'b1, 1'b0, 64'h0000, 64'hFF00, '0);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(accOut == 128'h00FF_0000, "R3 unsigned extreme", accOut, 128'h00FF_0000);

    // R4: wrap in lane 0 without carry into lane 1
    @(negedge clk);
    drive(1'b1, 2'd0, 1'b1, 1'b0, 64'hFF, 64'h00, 128'h0000_FFFF);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(accOut == 128'h0000_00FE, "R4 lane wrap", accOut, 128'h0000_00FE);

    // R8: idle cycles keep the result and raise no strobe
    held = accOut;
    @(negedge clk);
    @(negedge clk);
    check(accOut == held, "R8 hold", accOut, held);
    check(!accValid && !illegalOp, "R8 quiet", {accValid, illegalOp}, 0);

    // R5: size code 3 rejected
    @(negedge clk);
    drive(1'b1, 2'd3, 1'b1, 1'b0, 64'hFF, 64'h00, '0);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(illegalOp && !accValid, "R5 flag", {accValid, illegalOp}, 2'b01);
    check(accOut == held, "R5 result held", accOut, held);
    @(negedge clk);
    check(!illegalOp, "R5 single pulse", illegalOp, 0);

    // Legal then illegal back to back (R7 then R6)
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b1, 1'b0, 64'h0000_0000_0000_0010, 64'h0, 128'h5);
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b1, 1'b1, 64'hFFFF, 64'h0, '0);
    check(accOut == 128'h15 && accValid, "R7 first result", accOut, 128'h15);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(illegalOp && !accValid, "R6 flag", {accValid, illegalOp}, 2'b01);
    check(accOut == 128'h15, "R6 result held", accOut, 128'h15);

    // R5 and R6 together: one pulse, no update
    @(negedge clk);
    drive(1'b1, 2'd3, 1'b0, 1'b1, 64'h1, 64'h2, '1);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
    check(illegalOp && !accValid, "R5 R6 combined flag", {accValid, illegalOp}, 2'b01);
    check(accOut == 128'h15, "R6 combined held", accOut, 128'h15);

    // R9: reset mid-run clears the result
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(accOut == '0 && !accValid && !illegalOp, "R9 re-reset", accOut, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule